// File: doc/BRIEF.md
# Delay-Line Bring-Up Sequencer

This block prepares a clock-recovery delay line before the sampling-phase search of a high-speed card interface. A one-cycle start pulse launches it. It first checks whether the card clock and the bus mode call for a tuned sampling point at all. If they do not, it reports completion on the next cycle and touches nothing. Otherwise it runs a fixed chain of single-bit and field writes to the delay-line configuration word. It then waits, paced by a one-microsecond tick, for the line to report lock.

The first write goes to a vendor register. It drops the clock power-save bit so that the card clock keeps running during configuration. The delay line is then held in reset and power-down while a 3-bit frequency band code is loaded. The band code comes from a step table over the card clock in MHz. The line is then released, enabled, and its output is enabled. A lock that arrives within the allowed number of ticks ends the run with success. A lock that never arrives ends it with a timeout failure. A clock above the top step is flagged as out of range and loads band code 0.

Top module: `dl_bringup_seq`

## Requirements
- R1: After a synchronous reset, cfg_word is all zero, vend_pwrsave is 1, and cfg_wr, vend_wr, busy, done, fail and freq_oor are 0.
- R2: A start with fast_mode low, or with clk_mhz at or below 100, gives a done pulse in the cycle after start is sampled. That done has fail 0 and freq_oor 0, and the run makes no write and changes no register bit.
- R3: In a tuned run, the first write is a vendor write (vend_wr high) that sets vend_pwrsave to 0. It appears two cycles after the cycle in which start is sampled.
- R4: The eight writes come in this order: power-save clear, reset set (cfg_word bit 30), power-down set (bit 29), band field (bits 26:24), reset clear, power-down clear, enable set (bit 16), output enable set (bit 18). Every other cfg_word bit stays 0.
- R5: The band code is 0 up to 112 MHz, 1 up to 125, 2 up to 137, 3 up to 150, 4 up to 162, 5 up to 175, 6 up to 187 and 7 up to 200, all limits inclusive. The band field changes only while reset and power-down are both held.
- R6: In a tuned run, a clk_mhz above 200 sets freq_oor, and the band field written is 0.
- R7: A write strobe is high for one cycle per write. The eight writes fall on eight consecutive cycles, and cfg_wr and vend_wr are never high together.
- R8: In the lock wait, lock_in high at a clock edge ends the run: done pulses with fail 0 in the next cycle. Lock takes priority over a tick at the same edge.
- R9: If lock_in stays low through LOCK_US ticks of the wait, done pulses with fail 1 after the edge that consumes the LOCK_US-th tick.
- R10: A start while busy is ignored. After done, no write or done occurs without a new start.
- R11: done is a one-cycle pulse. fail and freq_oor keep their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to bring up the delay line |
| fast_mode | input | 1 | Bus is in one of the two top single-data-rate timing modes |
| clk_mhz | input | FREQ_W | Card clock frequency in MHz |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| lock_in | input | 1 | Lock status from the delay line |
| cfg_word | output | 32 | Delay-line configuration word |
| cfg_wr | output | 1 | Configuration word was written this cycle |
| vend_pwrsave | output | 1 | Clock power-save bit of the vendor register |
| vend_wr | output | 1 | Vendor register was written this cycle |
| busy | output | 1 | A bring-up run is in progress |
| done | output | 1 | Run finished (one-cycle pulse) |
| fail | output | 1 | Last run ended in lock timeout |
| freq_oor | output | 1 | Last tuned run had a clock above the table |

## Verification
The bench builds the block with its default parameters: an 8-bit clock field, an eight-step band table and a 50-tick lock window. The 8-bit field covers every frequency from 0 to 255 MHz. This includes the bypass region, every step edge of the table and the out-of-range span above 200 MHz. The 50-tick window is short enough that lock delays on both sides of the limit, including exactly LOCK_US and LOCK_US+1 ticks, can be reached many times with randomly spaced ticks.

// File: rtl/dl_bringup_pkg.sv
package dl_bringup_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PSAVE, S_RST_ON, S_PDN_ON, S_BAND,
    S_RST_OFF, S_PDN_OFF, S_EN_ON, S_OE_ON, S_WAIT
  } seq_state_t;

  // Field positions in the configuration word decoded by the delay line
  localparam int RST_BIT  = 30;
  localparam int PDN_BIT  = 29;
  localparam int BAND_LSB = 24;
  localparam int OE_BIT   = 18;
  localparam int EN_BIT   = 16;

  // Inclusive upper clock limit (MHz) of each band step
  function automatic int band_limit(input int idx);
    case (idx)
      0: band_limit = 112;
      1: band_limit = 125;
      2: band_limit = 137;
      3: band_limit = 150;
      4: band_limit = 162;
      5: band_limit = 175;
      6: band_limit = 187;
      default: band_limit = 200;
    endcase
  endfunction

endpackage

// File: rtl/dl_band_lut.sv
module dl_band_lut #(
  parameter int FREQ_W = 8,
  parameter int NBANDS = 8,
  localparam int CODE_W = $clog2(NBANDS)
) (
  input  logic [FREQ_W-1:0] freq,
  output logic [CODE_W-1:0] code,
  output logic              oor
);
  import dl_bringup_pkg::*;

  logic [NBANDS-1:0] above;

  // One comparator per step; the steps are monotone, so the code is a count
  for (genvar i = 0; i < NBANDS; i++) begin : g_step
    assign above[i] = int'(freq) > band_limit(i);
  end

  logic [CODE_W:0] nabove;
  always_comb begin
    nabove = '0;
    for (int i = 0; i < NBANDS; i++) begin
      nabove = nabove + {{CODE_W{1'b0}}, above[i]};
    end
  end

  assign oor  = above[NBANDS-1];
  assign code = oor ? '0 : nabove[CODE_W-1:0];

endmodule

// File: rtl/dl_lock_timer.sv
module dl_lock_timer #(
  parameter int LOCK_US = 50,
  localparam int CNT_W = $clog2(LOCK_US + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expired
);

  logic [CNT_W-1:0] cnt;

  assign expired = run && tick && (cnt == CNT_W'(LOCK_US - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: the window counter never passes the last tick of the window
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(LOCK_US));

  // R9: outside the wait the counter rests at zero
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0) || run);

endmodule

// File: rtl/dl_seq_fsm.sv
module dl_seq_fsm #(
  parameter int  CODE_W      = 3,
  parameter int  FREQ_W      = 8,
  parameter int  SKIP_MHZ    = 100,
  parameter bit  PSAVE_INIT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fast_mode,
  input  logic [FREQ_W-1:0] clk_mhz,
  input  logic [CODE_W-1:0] band_code,
  input  logic              band_oor,
  input  logic              lock_in,
  input  logic              expired,
  output logic              wait_lock,
  output logic              dl_rst,
  output logic              dl_pdn,
  output logic              dl_en,
  output logic              dl_oe,
  output logic [CODE_W-1:0] band_q,
  output logic              psave,
  output logic              cfg_wr,
  output logic              vend_wr,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              oor
);
  import dl_bringup_pkg::*;

  seq_state_t        state;
  logic [CODE_W-1:0] code_q;
  logic              need_tune;

  assign need_tune = fast_mode && (int'(clk_mhz) > SKIP_MHZ);
  assign wait_lock = (state == S_WAIT);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      dl_rst  <= 1'b0;
      dl_pdn  <= 1'b0;
      dl_en   <= 1'b0;
      dl_oe   <= 1'b0;
      band_q  <= '0;
      code_q  <= '0;
      psave   <= PSAVE_INIT;
      cfg_wr  <= 1'b0;
      vend_wr <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
      oor     <= 1'b0;
    end else begin
      cfg_wr  <= 1'b0;
      vend_wr <= 1'b0;
      done    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            fail <= 1'b0;
            if (need_tune) begin
              oor    <= band_oor;
              code_q <= band_code;
              state  <= S_PSAVE;
            end else begin
              oor  <= 1'b0;
              done <= 1'b1;
            end
          end
        end
        S_PSAVE: begin
          psave   <= 1'b0;
          vend_wr <= 1'b1;
          state   <= S_RST_ON;
        end
        S_RST_ON: begin
          dl_rst <= 1'b1;
          cfg_wr <= 1'b1;
          state  <= S_PDN_ON;
        end
        S_PDN_ON: begin
          dl_pdn <= 1'b1;
          cfg_wr <= 1'b1;
          state  <= S_BAND;
        end
        S_BAND: begin
          band_q <= code_q;
          cfg_wr <= 1'b1;
          state  <= S_RST_OFF;
        end
        S_RST_OFF: begin
          dl_rst <= 1'b0;
          cfg_wr <= 1'b1;
          state  <= S_PDN_OFF;
        end
        S_PDN_OFF: begin
          dl_pdn <= 1'b0;
          cfg_wr <= 1'b1;
          state  <= S_EN_ON;
        end
        S_EN_ON: begin
          dl_en  <= 1'b1;
          cfg_wr <= 1'b1;
          state  <= S_OE_ON;
        end
        S_OE_ON: begin
          dl_oe  <= 1'b1;
          cfg_wr <= 1'b1;
          state  <= S_WAIT;
        end
        S_WAIT: begin
          if (lock_in) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (expired) begin
            done  <= 1'b1;
            fail  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: the two registers are never written in the same cycle
  a_r7_single_write: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && vend_wr));

  // R5: the band field moves only while reset and power-down are held
  a_r5_band_window: assert property (@(posedge clk) disable iff (rst)
    !$stable(band_q) |-> (dl_rst && dl_pdn));

  // R4: output enable rises only on a released, enabled line
  a_r4_oe_after_en: assert property (@(posedge clk) disable iff (rst)
    $rose(dl_oe) |-> (dl_en && !dl_rst && !dl_pdn));

  // R3: reset is never asserted before power-save is off
  a_r3_psave_first: assert property (@(posedge clk) disable iff (rst)
    $rose(dl_rst) |-> !psave);

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: a start that needs no tuning finishes at once with no write
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !need_tune) |=> (done && !fail && !cfg_wr && !vend_wr));

  // R6: an out-of-range clock loads band code zero
  a_r6_oor_code: assert property (@(posedge clk) disable iff (rst)
    (oor && state == S_BAND) |=> (band_q == '0));

  // R10: a start while busy does not disturb the write chain
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state == S_RST_ON) |=> (state == S_PDN_ON));

endmodule

// File: rtl/dl_bringup_seq.sv
module dl_bringup_seq #(
  parameter int FREQ_W     = 8,
  parameter int NBANDS     = 8,
  parameter int SKIP_MHZ   = 100,
  parameter int LOCK_US    = 50,
  parameter bit PSAVE_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fast_mode,
  input  logic [FREQ_W-1:0] clk_mhz,
  input  logic              us_tick,
  input  logic              lock_in,
  output logic [31:0]       cfg_word,
  output logic              cfg_wr,
  output logic              vend_pwrsave,
  output logic              vend_wr,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              freq_oor
);
  import dl_bringup_pkg::*;

  localparam int CODE_W = $clog2(NBANDS);

  logic [CODE_W-1:0] band_code;
  logic              band_oor;
  logic              wait_lock;
  logic              expired;
  logic              dl_rst, dl_pdn, dl_en, dl_oe;
  logic [CODE_W-1:0] band_q;

  dl_band_lut #(.FREQ_W(FREQ_W), .NBANDS(NBANDS)) u_band (
    .freq (clk_mhz),
    .code (band_code),
    .oor  (band_oor)
  );

  dl_lock_timer #(.LOCK_US(LOCK_US)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (wait_lock),
    .tick    (us_tick),
    .expired (expired)
  );

  dl_seq_fsm #(
    .CODE_W(CODE_W), .FREQ_W(FREQ_W), .SKIP_MHZ(SKIP_MHZ), .PSAVE_INIT(PSAVE_INIT)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .fast_mode (fast_mode),
    .clk_mhz   (clk_mhz),
    .band_code (band_code),
    .band_oor  (band_oor),
    .lock_in   (lock_in),
    .expired   (expired),
    .wait_lock (wait_lock),
    .dl_rst    (dl_rst),
    .dl_pdn    (dl_pdn),
    .dl_en     (dl_en),
    .dl_oe     (dl_oe),
    .band_q    (band_q),
    .psave     (vend_pwrsave),
    .cfg_wr    (cfg_wr),
    .vend_wr   (vend_wr),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .oor       (freq_oor)
  );

  always_comb begin
    cfg_word = '0;
    cfg_word[RST_BIT] = dl_rst;
    cfg_word[PDN_BIT] = dl_pdn;
    cfg_word[EN_BIT]  = dl_en;
    cfg_word[OE_BIT]  = dl_oe;
    cfg_word[BAND_LSB +: CODE_W] = band_q;
  end

endmodule

// File: tb/dl_bringup_seq_tb.sv
module dl_bringup_seq_tb_top;

  localparam int LOCK_US = 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        fast_mode = 1'b0;
  logic [7:0]  clk_mhz = '0;
  logic        us_tick = 1'b0;
  logic        lock_in = 1'b0;
  logic [31:0] cfg_word;
  logic        cfg_wr, vend_pwrsave, vend_wr, busy, done, fail, freq_oor;

  int checks = 0;
  int errors = 0;

  logic [31:0] img_cfg;
  logic        img_ps;

  always #4 clk = ~clk;

  dl_bringup_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .fast_mode(fast_mode),
    .clk_mhz(clk_mhz), .us_tick(us_tick), .lock_in(lock_in),
    .cfg_word(cfg_word), .cfg_wr(cfg_wr), .vend_pwrsave(vend_pwrsave),
    .vend_wr(vend_wr), .busy(busy), .done(done), .fail(fail),
    .freq_oor(freq_oor)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_band(input int f);
    if (f <= 112) return 0;
    if (f <= 125) return 1;
    if (f <= 137) return 2;
    if (f <= 150) return 3;
    if (f <= 162) return 4;
    if (f <= 175) return 5;
    if (f <= 187) return 6;
    if (f <= 200) return 7;
    return 0;
  endfunction

  // One run: mhz, mode, lock delay in ticks, and whether to poke start while busy
  task automatic run_case(input int mhz, input bit fast, input int dly, input bit poke);
    bit need;
    int cyc, widx, tk, lock_cyc;
    bit in_wait, seen_done;
    need = fast && (mhz > 100);
    @(posedge clk); #1;
    clk_mhz = mhz[7:0]; fast_mode = fast; start = 1'b1; us_tick = 1'b0;
    cyc = 0; widx = 0; tk = 0; in_wait = 0; seen_done = 0; lock_cyc = -1;
    lock_in = 1'b0;
    while (!seen_done && cyc < 3000) begin
      @(posedge clk); #1;
      start = (poke && cyc == 5) ? 1'b1 : 1'b0;
      us_tick = ($urandom % 3) == 0;
      @(negedge clk);
      cyc++;
      if (done) begin
        seen_done = 1;
        if (!need) begin
          check(cyc == 1, "R2 bypass latency", cyc, 1);
          check(widx == 0, "R2 no writes", widx, 0);
          check(fail == 0 && freq_oor == 0, "R2 flags", {fail, freq_oor}, 0);
        end else begin
          check(widx == 8, "R7 write count", widx, 8);
          check(freq_oor == (mhz > 200), "R6 out of range flag", freq_oor, mhz > 200);
          if (dly <= LOCK_US) begin
            check(fail == 0, "R8 lock success", fail, 0);
            check(cyc == lock_cyc + 1, "R8 done after lock", cyc, lock_cyc + 1);
            check(tk == dly, "R8 ticks before lock", tk, dly);
          end else begin
            check(fail == 1, "R9 timeout flag", fail, 1);
            check(tk == LOCK_US, "R9 timeout tick count", tk, LOCK_US);
          end
        end
      end else begin
        if (cfg_wr || vend_wr) begin
          check(!(cfg_wr && vend_wr), "R7 one strobe", {cfg_wr, vend_wr}, 1);
          check(cyc == widx + 2, "R7 consecutive writes", cyc, widx + 2);
          check(vend_wr == (widx == 0), "R3 vendor write first", vend_wr, widx == 0);
          case (widx)
            0: img_ps = 1'b0;
            1: img_cfg[30] = 1'b1;
            2: img_cfg[29] = 1'b1;
            3: img_cfg[26:24] = exp_band(mhz);
            4: img_cfg[30] = 1'b0;
            5: img_cfg[29] = 1'b0;
            6: img_cfg[16] = 1'b1;
            default: img_cfg[18] = 1'b1;
          endcase
          if (widx == 3)
            check(cfg_word[26:24] == exp_band(mhz), "R5 band code", cfg_word[26:24], exp_band(mhz));
          if (widx == 7) in_wait = 1;
          widx++;
        end
        check(cfg_word == img_cfg, "R4 config word image", cfg_word, img_cfg);
        check(vend_pwrsave == img_ps, "R3 power-save bit", vend_pwrsave, img_ps);
        if (in_wait) begin
          if (us_tick && !lock_in) tk++;
          if (!lock_in && tk >= dly) begin
            lock_in = 1'b1;
            lock_cyc = cyc;
          end
        end
      end
    end
    if (!seen_done) check(0, "R8 watchdog done", 0, 1);
    lock_in = 1'b0; start = 1'b0;
    // R11 and R10: done is a single pulse and nothing follows without start
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!done && !cfg_wr && !vend_wr && !busy, "R10 quiet after done",
            {done, cfg_wr, vend_wr, busy}, 0);
      check(fail == (need && dly > LOCK_US), "R11 fail held", fail, need && dly > LOCK_US);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    img_cfg = '0;
    img_ps  = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cfg_word == 0, "R1 config word reset", cfg_word, 0);
    check(vend_pwrsave == 1, "R1 power-save reset", vend_pwrsave, 1);
    check({cfg_wr, vend_wr, busy, done, fail, freq_oor} == 0, "R1 status reset",
          {cfg_wr, vend_wr, busy, done, fail, freq_oor}, 0);
    // Directed corners
    run_case(100, 1, 3, 0);      // R2 at the threshold
    run_case(150, 0, 3, 0);      // R2 slow mode
    run_case(101, 1, 0, 0);      // R8 immediate lock
    run_case(112, 1, 5, 0);      // R5 step edge
    run_case(113, 1, 5, 0);
    run_case(200, 1, LOCK_US, 0);      // R8 lock on last tick
    run_case(201, 1, LOCK_US + 1, 0);  // R6 and R9
    run_case(255, 1, 10, 1);     // R6, R10 start poked while busy
    run_case(137, 1, 80, 1);     // R9 with poke
    // Random mix
    for (int n = 0; n < 40; n++) begin
      run_case($urandom % 256, ($urandom % 4) != 0, $urandom % 71, ($urandom % 5) == 0);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule